// File: doc/BRIEF.md
# Dual-Mode Sleep and Wakeup Controller

This block sequences one processor core between a running state and two sleep modes. A wait-for-interrupt request parks the core in a light sleep that only an interrupt-class source can end. A wait-for-event request parks it in a deeper sleep that also ends on an event. The deeper sleep asks the wake logic to drop into a low-power state. In both sleep modes the core clock enable is low, so register context is held and execution resumes at the instruction after the request once the enable returns.

Wakeup is not instant. After a valid wake source is seen, the block spends a fixed number of cycles in a waking state before the clock enable rises. The count is `IRQ_LAT` cycles when leaving the interrupt sleep and `EVT_LAT` cycles when leaving the event sleep. A one-cycle done pulse marks the first running cycle. Reset ends any sleep at once, with no latency. An event that arrives while the core is not in event sleep is held in a sticky flag. The next wait-for-event request then uses up that flag instead of sleeping. Each instance serves one core. Other cores can wake it through a vector of inter-processor interrupt inputs.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: When `rst_n` is sampled low, the next cycle shows `state_o`=0 (run), `core_clk_en`=1, `wake_lp_req`=0 and `wake_done`=0. This applies from any state, with no wake latency and no done pulse. Reset also clears the sticky event flag.
- R2: In run, a `wfi_req` with no interrupt-class source (`irq_pend`, any `ipi_in` bit, `dbg_halt`) present gives `state_o`=1 and `core_clk_en`=0 in the next cycle.
- R3: In state 1 only `irq_pend`, any `ipi_in` bit or `dbg_halt` starts a wakeup. `evt_in` leaves the state at 1.
- R4: In run, a `wfe_req` (with `wfi_req` low) with no interrupt-class source, no `evt_in` and a clear sticky flag gives `state_o`=2, `core_clk_en`=0 and `wake_lp_req`=1 in the next cycle.
- R5: In state 2, any interrupt-class source or `evt_in` starts a wakeup.
- R6: The edge that samples a valid wake source moves the block to state 3 (waking). It stays there for exactly `IRQ_LAT` cycles (from state 1) or `EVT_LAT` cycles (from state 2), then returns to run with `core_clk_en`=1.
- R7: `wake_done` is high for exactly the first run cycle after waking, and low at all other times.
- R8: A sleep request is ignored, and the block stays in run, when a wake source valid for the requested mode is asserted in the same cycle.
- R9: `evt_in` seen in any state other than 2 sets a sticky flag. The next `wfe_req` from run clears the flag and does not sleep. A later `wfe_req` then sleeps normally.
- R10: Sleep requests are ignored in states 1, 2 and 3. The waking count is not disturbed by them.
- R11: When `wfi_req` and `wfe_req` arrive together in run, the interrupt sleep is chosen.
- R12: `wake_lp_req` is high only while `state_o`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset, also an immediate wake source |
| wfi_req | input | 1 | Request interrupt-wait sleep |
| wfe_req | input | 1 | Request event-wait sleep |
| irq_pend | input | 1 | A pending interrupt exists |
| ipi_in | input | N_IPI | Inter-processor interrupts from other cores |
| dbg_halt | input | 1 | Debug halt request |
| evt_in | input | 1 | Event signal |
| core_clk_en | output | 1 | Core clock enable, high only in run |
| wake_lp_req | output | 1 | Wake logic low-power request |
| state_o | output | 2 | 0 run, 1 interrupt sleep, 2 event sleep, 3 waking |
| wake_done | output | 1 | One-cycle pulse on the first run cycle after waking |

## Verification
The hardest case to reach is the sticky event flag. It is set silently and is only visible as a wait-for-event request that fails to sleep. The bench raises `evt_in` while in run, or while in interrupt sleep before waking. It then issues two event-sleep requests in a row and checks that the first stays in run and the second sleeps. The bench also measures the waking count for every wake source in both modes. It injects requests and reset in the middle of that count to show that requests leave it alone and that reset cuts it short.

// File: rtl/slp_pkg.sv
// Shared types for the sleep/wakeup controller.
// Assumes: the two-bit state encoding is visible at the top ports.
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IWAIT = 2'd1,
        ST_EWAIT = 2'd2,
        ST_WAKE  = 2'd3
    } slp_state_e;
endpackage

// File: rtl/slp_wake_qual.sv
// Wake source qualification and the sticky event flag.
// Puts interrupt-class sources into one term and event-class sources into another.
// Assumes: consume is only raised by the sequencer while in run.
module slp_wake_qual
    import slp_pkg::*;
#(
    parameter int N_IPI = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slp_state_e       state,
    input  logic             irq_pend,
    input  logic [N_IPI-1:0] ipi_in,
    input  logic             dbg_halt,
    input  logic             evt_in,
    input  logic             consume,
    output logic             wake_int,
    output logic             wake_evt
);
    logic evt_flag_q;

    // Interrupt-class sources wake either sleep mode.
    assign wake_int = irq_pend | (|ipi_in) | dbg_halt;
    // Event-class sources: the live event or an event remembered earlier.
    assign wake_evt = evt_in | evt_flag_q;

    // Sticky flag: set by an event outside event sleep, cleared when a request uses it up.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_flag_q <= 1'b0;
        else if (consume)
            evt_flag_q <= 1'b0;
        else if (evt_in && state != ST_EWAIT)
            evt_flag_q <= 1'b1;
    end

    // R9: the flag is never found set while in event sleep
    assert_flag_clear_in_ewait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EWAIT) |-> !evt_flag_q);
    // R9: an event outside event sleep without a consume leaves the flag set
    assert_flag_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in && state != ST_EWAIT && !consume) |=> evt_flag_q);
endmodule

// File: rtl/slp_lat_cnt.sv
// Wake latency down-counter.
// Loads the latency minus one for the mode being left, then counts down to zero.
// Assumes: both latencies are at least one cycle.
module slp_lat_cnt #(
    parameter int IRQ_LAT = 2,
    parameter int EVT_LAT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_evt,
    output logic zero
);
    localparam int MAX_LAT = (EVT_LAT > IRQ_LAT) ? EVT_LAT : IRQ_LAT;
    localparam int CW      = $clog2(MAX_LAT + 1);
    localparam logic [CW-1:0] IRQ_LOAD = CW'(IRQ_LAT - 1);
    localparam logic [CW-1:0] EVT_LOAD = CW'(EVT_LAT - 1);

    logic [CW-1:0] cnt_q;

    // Load on a wake decision, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= sel_evt ? EVT_LOAD : IRQ_LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    initial begin
        assert_lat_nonzero_R6: assert (IRQ_LAT >= 1 && EVT_LAT >= 1);
    end

    // R6: the counter steps down by one when it is not loaded
    assert_cnt_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R6: a load takes the latency of the chosen mode
    assert_cnt_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && sel_evt) |=> (cnt_q == EVT_LOAD));
endmodule

// File: rtl/slp_fsm.sv
// Sleep/wake sequencer: run, two sleep states and a timed waking state.
// Assumes: wake terms come from slp_wake_qual and zero comes from slp_lat_cnt.
module slp_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_req,
    input  logic       wfe_req,
    input  logic       wake_int,
    input  logic       wake_evt,
    input  logic       cnt_zero,
    output slp_state_e state,
    output logic       cnt_load,
    output logic       cnt_sel_evt,
    output logic       consume,
    output logic       done_q
);
    slp_state_e state_q, state_d;
    logic       done_d;

    // Next state and control decode for the current state.
    always_comb begin
        state_d     = state_q;
        cnt_load    = 1'b0;
        cnt_sel_evt = 1'b0;
        consume     = 1'b0;
        done_d      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (wfi_req) begin
                    if (!wake_int) state_d = ST_IWAIT;
                end else if (wfe_req) begin
                    consume = 1'b1;
                    if (!(wake_int || wake_evt)) state_d = ST_EWAIT;
                end
            end
            ST_IWAIT: begin
                if (wake_int) begin
                    state_d  = ST_WAKE;
                    cnt_load = 1'b1;
                end
            end
            ST_EWAIT: begin
                if (wake_int || wake_evt) begin
                    state_d     = ST_WAKE;
                    cnt_load    = 1'b1;
                    cnt_sel_evt = 1'b1;
                end
            end
            ST_WAKE: begin
                if (cnt_zero) begin
                    state_d = ST_RUN;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State and done-pulse registers; reset returns to run at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign state = state_q;

    // R3: interrupt sleep holds while no interrupt-class source is present
    assert_iwait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IWAIT && !wake_int) |=> (state_q == ST_IWAIT));
    // R10: waking is not left early whatever the requests do
    assert_wake_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !cnt_zero) |=> (state_q == ST_WAKE));
    // R7: the done pulse lasts one cycle and lands in run
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    assert_done_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_RUN && $past(state_q) == ST_WAKE));
    // R2: a sleep state is only ever entered from run
    assert_sleep_from_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IWAIT) ##1 (state_q == ST_IWAIT) |-> ($past(state_q) == ST_RUN));
endmodule

// File: rtl/sleep_wake_ctrl.sv
// Top of the dual-mode sleep/wakeup controller.
// Connects the wake qualification, the sequencer and the latency counter,
// and decodes the clock enable and the wake-logic low-power request.
// Assumes: clk is always running; core clock gating itself is done outside.
module sleep_wake_ctrl
    import slp_pkg::*;
#(
    parameter int N_IPI   = 2,
    parameter int IRQ_LAT = 2,
    parameter int EVT_LAT = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req,
    input  logic             wfe_req,
    input  logic             irq_pend,
    input  logic [N_IPI-1:0] ipi_in,
    input  logic             dbg_halt,
    input  logic             evt_in,
    output logic             core_clk_en,
    output logic             wake_lp_req,
    output logic [1:0]       state_o,
    output logic             wake_done
);
    slp_state_e state;
    logic wake_int, wake_evt, consume;
    logic cnt_load, cnt_sel_evt, cnt_zero;

    slp_wake_qual #(.N_IPI(N_IPI)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .irq_pend (irq_pend),
        .ipi_in   (ipi_in),
        .dbg_halt (dbg_halt),
        .evt_in   (evt_in),
        .consume  (consume),
        .wake_int (wake_int),
        .wake_evt (wake_evt)
    );

    slp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wfi_req     (wfi_req),
        .wfe_req     (wfe_req),
        .wake_int    (wake_int),
        .wake_evt    (wake_evt),
        .cnt_zero    (cnt_zero),
        .state       (state),
        .cnt_load    (cnt_load),
        .cnt_sel_evt (cnt_sel_evt),
        .consume     (consume),
        .done_q      (wake_done)
    );

    slp_lat_cnt #(.IRQ_LAT(IRQ_LAT), .EVT_LAT(EVT_LAT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .sel_evt (cnt_sel_evt),
        .zero    (cnt_zero)
    );

    assign core_clk_en = (state == ST_RUN);
    assign wake_lp_req = (state == ST_EWAIT);
    assign state_o     = state;

    // R12: the low-power request only rises on entry to event sleep from run
    assert_lp_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_lp_req) |-> ($past(state) == ST_RUN));
    // R5: event sleep is left on a live event
    assert_ewait_evt_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EWAIT && evt_in) |=> (state == ST_WAKE));
endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_IPI   = 2;
    localparam int IRQ_LAT = 2;
    localparam int EVT_LAT = 30;
    localparam int N_SRC   = 5; // 0 irq, 1 ipi0, 2 ipi1, 3 dbg, 4 evt

    logic clk = 1'b0;
    logic rst_n, wfi_req, wfe_req, irq_pend, dbg_halt, evt_in;
    logic [N_IPI-1:0] ipi_in;
    logic core_clk_en, wake_lp_req, wake_done;
    logic [1:0] state_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_wake_ctrl #(.N_IPI(N_IPI), .IRQ_LAT(IRQ_LAT), .EVT_LAT(EVT_LAT)) u_sleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .irq_pend(irq_pend), .ipi_in(ipi_in), .dbg_halt(dbg_halt), .evt_in(evt_in),
        .core_clk_en(core_clk_en), .wake_lp_req(wake_lp_req),
        .state_o(state_o), .wake_done(wake_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_src(input int idx, input logic v);
        case (idx)
            0: irq_pend  = v;
            1: ipi_in[0] = v;
            2: ipi_in[1] = v;
            3: dbg_halt  = v;
            default: evt_in = v;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue a one-cycle request from run; mode 0 interrupt sleep, 1 event sleep.
    task automatic request(input int mode);
        @(negedge clk);
        if (mode == 0) wfi_req = 1'b1; else wfe_req = 1'b1;
        @(negedge clk);
        wfi_req = 1'b0;
        wfe_req = 1'b0;
    endtask

    // Pulse a wake source and measure the waking count to run.
    task automatic wake_and_time(input int src, input int lat, input string tag);
        int n;
        set_src(src, 1'b1);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                set_src(src, 1'b0);
                check({tag, " R6 waking state"}, state_o, 3);
                check({tag, " R12 lp low while waking"}, wake_lp_req, 0);
            end
            if (core_clk_en) break;
        end
        check({tag, " R6 latency"}, n - 1, lat);
        check({tag, " R7 done pulse"}, wake_done, 1);
        @(negedge clk);
        check({tag, " R7 done single"}, wake_done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wfi_req = 0; wfe_req = 0; irq_pend = 0; ipi_in = '0;
        dbg_halt = 0; evt_in = 0;
        do_reset();
        @(negedge clk);
        check("R1 reset state", state_o, 0);
        check("R1 reset clk_en", core_clk_en, 1);
        check("R1 reset lp", wake_lp_req, 0);
        check("R1 reset done", wake_done, 0);

        // Sweep: each mode against each wake source.
        for (int mode = 0; mode < 2; mode++) begin
            for (int src = 0; src < N_SRC; src++) begin
                do_reset();
                request(mode);
                check(mode == 0 ? "R2 enter iwait" : "R4 enter ewait", state_o, mode + 1);
                check("R2 R4 clk_en low", core_clk_en, 0);
                check("R12 lp by mode", wake_lp_req, mode);
                if (mode == 0 && src == 4) begin
                    set_src(src, 1'b1);
                    repeat (5) @(negedge clk);
                    check("R3 event ignored in iwait", state_o, 1);
                    set_src(src, 1'b0);
                end else begin
                    wake_and_time(src, mode == 0 ? IRQ_LAT : EVT_LAT,
                                  mode == 0 ? "R3 iwait" : "R5 ewait");
                end
            end
        end

        // R8: source already present at request time.
        for (int mode = 0; mode < 2; mode++) begin
            for (int src = 0; src < N_SRC; src++) begin
                do_reset();
                @(negedge clk);
                set_src(src, 1'b1);
                if (mode == 0) wfi_req = 1'b1; else wfe_req = 1'b1;
                @(negedge clk);
                wfi_req = 0; wfe_req = 0; set_src(src, 1'b0);
                check("R8 request with live source",
                      state_o, (mode == 0 && src == 4) ? 1 : 0);
            end
        end

        // R9: sticky event flag, set in run.
        do_reset();
        @(negedge clk); evt_in = 1; @(negedge clk); evt_in = 0;
        repeat (3) @(negedge clk);
        request(1);
        check("R9 flagged request stays run", state_o, 0);
        request(1);
        check("R9 second request sleeps", state_o, 2);
        // R9: flag set while in interrupt sleep survives the wake.
        do_reset();
        request(0);
        @(negedge clk); evt_in = 1; @(negedge clk); evt_in = 0;
        wake_and_time(0, IRQ_LAT, "R9 iwait");
        request(1);
        check("R9 flag from iwait", state_o, 0);
        // R1: reset clears the flag.
        do_reset();
        @(negedge clk); evt_in = 1; @(negedge clk); evt_in = 0;
        do_reset();
        request(1);
        check("R1 reset clears flag", state_o, 2);

        // R10: requests ignored in sleep and while waking.
        do_reset();
        request(0);
        request(1);
        check("R10 wfe_req in iwait", state_o, 1);
        do_reset();
        request(1);
        @(negedge clk); evt_in = 1; @(negedge clk); evt_in = 0;
        wfi_req = 1; wfe_req = 1;
        for (int k = 2; k <= EVT_LAT + 1; k++) begin
            @(negedge clk);
            if (k == EVT_LAT) check("R10 still waking late", state_o, 3);
        end
        wfi_req = 0; wfe_req = 0;
        check("R10 count undisturbed", core_clk_en, 1);

        // R11: both requests together pick interrupt sleep.
        do_reset();
        @(negedge clk); wfi_req = 1; wfe_req = 1;
        @(negedge clk); wfi_req = 0; wfe_req = 0;
        check("R11 priority", state_o, 1);

        // R1: reset exits sleep and waking at once, no done pulse.
        request(1);
        check("R1 pre in sleep", state_o, 1);
        do_reset();
        check("R1 exit sleep", core_clk_en, 1);
        request(1);
        @(negedge clk); dbg_halt = 1; @(negedge clk); dbg_halt = 0;
        repeat (4) @(negedge clk);
        check("R1 pre in waking", state_o, 3);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        check("R1 exit waking state", state_o, 0);
        check("R1 no done on reset", wake_done, 0);
        @(negedge clk);
        check("R1 still no done", wake_done, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule